// File: doc/BRIEF.md
# Partial Address Chip-Select Decoder

This block turns the address and bus strobes of an 8-bit processor with a 16-bit address space into two active-low chip selects, one for a ROM device and one for a RAM device. It also produces the device-local address for each of them. The decode is partial on purpose. Only the address lines that separate the two regions are examined. A device narrower than its region therefore repeats throughout that region.

A parameter picks one of two layouts. In the half-split layout, the most significant address bit alone chooses the device: ROM sits in the lower 32 KiB and RAM in the upper 32 KiB. In the small-boot layout, a group of high address lines is OR-reduced. ROM answers only when every line in that group is zero, which leaves a small boot area at the bottom of memory. Every other address goes to RAM. The selects follow the inputs combinationally. They are qualified by the memory-request strobe, which marks both instruction fetches and data accesses. They stay released during I/O cycles. No fetch-cycle indication takes part in the decode, because code and data share one address space.

Top module: `cs_decoder`

## Requirements
- R1: In half-split mode (MODE = 0), a memory cycle with address bit 15 at 0 drives rom_cs_n_o to 0 and ram_cs_n_o to 1. This includes the boundary address 0x7FFF.
- R2: In half-split mode, a memory cycle with address bit 15 at 1 drives ram_cs_n_o to 0 and rom_cs_n_o to 1. This includes the boundary address 0x8000.
- R3: In small-boot mode (MODE = 1, BOOT_LO = 9), a memory cycle with address bits 15 down to 9 all 0 drives rom_cs_n_o to 0 and ram_cs_n_o to 1. This covers 0x0000 through 0x01FF.
- R4: In small-boot mode, a memory cycle with any of address bits 15 down to 9 set drives ram_cs_n_o to 0 and rom_cs_n_o to 1. Examples are 0x0200 and 0x8000.
- R5: While mreq_n_i is 1, both chip selects are 1 for every address.
- R6: While iorq_n_i is 0, both chip selects are 1, even when mreq_n_i is 0.
- R7: rom_cs_n_o and ram_cs_n_o are never 0 at the same time.
- R8: rom_addr_o equals addr_i[ROM_AW-1:0] and ram_addr_o equals addr_i[RAM_AW-1:0]. Two addresses that differ only above a device's width, and lie in that device's region, give the same local address and the same select (aliasing).
- R9: The outputs are combinational. A new input value shows on the outputs within the same clock cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | ADDR_W (16) | Processor address bus |
| mreq_n_i | input | 1 | Memory-request strobe, active low |
| iorq_n_i | input | 1 | I/O-request strobe, active low |
| rom_cs_n_o | output | 1 | ROM chip select, active low |
| ram_cs_n_o | output | 1 | RAM chip select, active low |
| rom_addr_o | output | ROM_AW | Address seen by the ROM device |
| ram_addr_o | output | RAM_AW | Address seen by the RAM device |

## Verification
The decode is driven with addresses on each side of every region edge: 0x7FFF and 0x8000 for the half split, and 0x01FF, 0x0200 and 0x8000 for the boot area. These patterns show whether the right lines are tested and whether the boundary is off by one. Pairs of addresses that differ only in unused high bits show whether aliasing and the local-address masking are correct. Idle cycles and I/O cycles are driven at ROM and RAM addresses alike. They show that the strobe qualification, and not the address, releases both selects.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  typedef enum logic {
    DEC_HALF_SPLIT = 1'b0,
    DEC_SMALL_BOOT = 1'b1
  } dec_mode_e;
endpackage

// File: rtl/cs_region_sel.sv
module cs_region_sel #(
  parameter int HI_W = 1
) (
  input  logic [HI_W-1:0] hi_bits_i,
  output logic            rom_hit_o
);
  // ROM owns the region where every tested high line is zero.
  // A one-bit group gives the half split.
  // A wider group gives a small boot window.
  assign rom_hit_o = ~(|hi_bits_i);
endmodule

// File: rtl/cs_select_drive.sv
module cs_select_drive (
  input  logic mreq_n_i,
  input  logic iorq_n_i,
  input  logic rom_hit_i,
  output logic rom_cs_n_o,
  output logic ram_cs_n_o
);
  logic mem_go;

  assign mem_go     = ~mreq_n_i & iorq_n_i;
  assign rom_cs_n_o = ~(mem_go & rom_hit_i);
  assign ram_cs_n_o = ~(mem_go & ~rom_hit_i);

  always_comb begin
    // R5
    idle_release_chk: assert (!(mreq_n_i && (!rom_cs_n_o || !ram_cs_n_o)));
    // R6
    io_release_chk: assert (!(!iorq_n_i && (!rom_cs_n_o || !ram_cs_n_o)));
  end
endmodule

// File: rtl/cs_local_addr.sv
module cs_local_addr #(
  parameter int OUT_W = 15
) (
  input  logic [OUT_W-1:0] addr_slice_i,
  output logic [OUT_W-1:0] dev_addr_o
);
  assign dev_addr_o = addr_slice_i;
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_dec_pkg::*;
#(
  parameter int        ADDR_W  = 16,
  parameter dec_mode_e MODE    = DEC_HALF_SPLIT,
  parameter int        BOOT_LO = 9,
  parameter int        ROM_AW  = 15,
  parameter int        RAM_AW  = 15
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mreq_n_i,
  input  logic              iorq_n_i,
  output logic              rom_cs_n_o,
  output logic              ram_cs_n_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic [RAM_AW-1:0] ram_addr_o
);
  localparam int SEL_LO = (MODE == DEC_HALF_SPLIT) ? ADDR_W - 1 : BOOT_LO;
  localparam int SEL_W  = ADDR_W - SEL_LO;

  logic rom_hit;

  cs_region_sel #(.HI_W(SEL_W)) u_region (
    .hi_bits_i (addr_i[ADDR_W-1:SEL_LO]),
    .rom_hit_o (rom_hit)
  );

  cs_select_drive u_drive (
    .mreq_n_i   (mreq_n_i),
    .iorq_n_i   (iorq_n_i),
    .rom_hit_i  (rom_hit),
    .rom_cs_n_o (rom_cs_n_o),
    .ram_cs_n_o (ram_cs_n_o)
  );

  cs_local_addr #(.OUT_W(ROM_AW)) u_rom_addr (
    .addr_slice_i (addr_i[ROM_AW-1:0]),
    .dev_addr_o   (rom_addr_o)
  );

  cs_local_addr #(.OUT_W(RAM_AW)) u_ram_addr (
    .addr_slice_i (addr_i[RAM_AW-1:0]),
    .dev_addr_o   (ram_addr_o)
  );

  always_comb begin
    // R7
    one_select_chk: assert (rom_cs_n_o || ram_cs_n_o);
    if (!mreq_n_i && iorq_n_i) begin
      if (MODE == DEC_HALF_SPLIT) begin
        // R1
        half_rom_chk: assert (addr_i[ADDR_W-1] || (!rom_cs_n_o && ram_cs_n_o));
        // R2
        half_ram_chk: assert (!addr_i[ADDR_W-1] || (!ram_cs_n_o && rom_cs_n_o));
      end else begin
        // R3
        boot_rom_chk: assert ((addr_i >> BOOT_LO) != 0 || !rom_cs_n_o);
        // R4
        boot_ram_chk: assert ((addr_i >> BOOT_LO) == 0 || !ram_cs_n_o);
      end
    end
  end
endmodule

// File: tb/cs_decoder_tb.sv
module cs_decoder_tb;
  import cs_dec_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0;
  logic        mreq_n = 1'b1;
  logic        iorq_n = 1'b1;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  logic        h_rom_n, h_ram_n, b_rom_n, b_ram_n;
  logic [12:0] h_rom_a;
  logic [13:0] h_ram_a;
  logic [8:0]  b_rom_a;
  logic [15:0] b_ram_a;

  always #4 clk = ~clk;

  cs_decoder #(.MODE(DEC_HALF_SPLIT), .ROM_AW(13), .RAM_AW(14)) u_dut (
    .addr_i(addr), .mreq_n_i(mreq_n), .iorq_n_i(iorq_n),
    .rom_cs_n_o(h_rom_n), .ram_cs_n_o(h_ram_n),
    .rom_addr_o(h_rom_a), .ram_addr_o(h_ram_a)
  );

  cs_decoder #(.MODE(DEC_SMALL_BOOT), .BOOT_LO(9), .ROM_AW(9), .RAM_AW(16)) u_dut_boot (
    .addr_i(addr), .mreq_n_i(mreq_n), .iorq_n_i(iorq_n),
    .rom_cs_n_o(b_rom_n), .ram_cs_n_o(b_ram_n),
    .rom_addr_o(b_rom_a), .ram_addr_o(b_ram_a)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive after a rising edge; sample at the following falling edge (same cycle).
  task automatic put(input logic [15:0] a, input logic mq, input logic io);
    @(posedge clk);
    addr = a; mreq_n = mq; iorq_n = io;
    @(negedge clk);
  endtask

  task automatic t_idle();
    foreach (addr[i]) ;
    put(16'h0000, 1'b1, 1'b1);
    chk("R5 half rom", h_rom_n, 1); chk("R5 half ram", h_ram_n, 1);
    chk("R5 boot rom", b_rom_n, 1); chk("R5 boot ram", b_ram_n, 1);
    put(16'hF000, 1'b1, 1'b1);
    chk("R5 half ram hi", h_ram_n, 1); chk("R5 boot ram hi", b_ram_n, 1);
  endtask

  task automatic t_io();
    put(16'h0010, 1'b0, 1'b0);
    chk("R6 half rom", h_rom_n, 1); chk("R6 boot rom", b_rom_n, 1);
    put(16'h9000, 1'b0, 1'b0);
    chk("R6 half ram", h_ram_n, 1); chk("R6 boot ram", b_ram_n, 1);
  endtask

  task automatic t_half_split();
    put(16'h7FFF, 1'b0, 1'b1);
    chk("R1 rom at 7FFF", h_rom_n, 0); chk("R1 ram off", h_ram_n, 1);
    put(16'h8000, 1'b0, 1'b1);
    chk("R2 ram at 8000 same cycle R9", h_ram_n, 0); chk("R2 rom off", h_rom_n, 1);
    chk("R7 not both", int'(!h_rom_n && !h_ram_n), 0);
  endtask

  task automatic t_alias();
    put(16'h0123, 1'b0, 1'b1);
    chk("R8 rom addr 0123", h_rom_a, 16'h0123);
    put(16'h6123, 1'b0, 1'b1);
    chk("R8 rom alias 6123", h_rom_a, 16'h0123); chk("R8 alias selects rom", h_rom_n, 0);
    put(16'h8456, 1'b0, 1'b1);
    chk("R8 ram addr 8456", h_ram_a, 16'h0456);
    put(16'hC456, 1'b0, 1'b1);
    chk("R8 ram alias C456", h_ram_a, 16'h0456); chk("R8 alias selects ram", h_ram_n, 0);
    chk("R8 boot ram full addr", b_ram_a, 16'hC456);
  endtask

  task automatic t_boot();
    put(16'h0000, 1'b0, 1'b1);
    chk("R3 rom at 0000", b_rom_n, 0); chk("R3 ram off", b_ram_n, 1);
    put(16'h01FF, 1'b0, 1'b1);
    chk("R3 rom at 01FF", b_rom_n, 0); chk("R8 boot rom addr", b_rom_a, 16'h01FF);
    put(16'h0200, 1'b0, 1'b1);
    chk("R4 ram at 0200", b_ram_n, 0); chk("R4 rom off", b_rom_n, 1);
    put(16'h8000, 1'b0, 1'b1);
    chk("R4 ram at 8000", b_ram_n, 0); chk("R7 boot not both", int'(!b_rom_n && !b_ram_n), 0);
    put(16'h0600, 1'b0, 1'b1);
    chk("R8 boot alias rom addr no select", b_rom_n, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset state rom", h_rom_n, 1);
    chk("R5 reset state ram", h_ram_n, 1);
    t_idle();
    t_io();
    t_half_split();
    t_alias();
    t_boot();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule